// File: doc/BRIEF.md
# Three-Level Nesting Interrupt Controller

This block sits between a set of peripheral interrupt lines and a processor. Each line is given one of three service levels: low, medium or high. A single-cycle pulse on a line marks that line pending. A separate oscillator-failure input raises a non-maskable request that ranks above all three levels. From the pending requests the block picks one candidate. It offers that candidate to the processor as a word-addressed vector, together with the candidate's level, over a valid/ready handshake. A handshake counts as an acknowledge.

The block keeps one active flag for each level, plus one for the non-maskable request. These flags model nested service routines. A candidate is offered only if its level ranks strictly above the highest level that is currently active. A return-from-interrupt pulse closes the innermost (highest) active level. Inside the medium and high levels, the lowest-numbered source wins. Inside the low level, a mode input chooses between the same fixed order and a rotating order. The rotating order guarantees that every low source is reached within one pass over all the sources. A select input moves the whole vector table from address zero to a boot-section base.

The offer side follows valid/ready rules. Valid rises only when a candidate exists that may preempt. Ready may be held high at any time, and nothing happens unless valid is also high. While valid waits for ready, the offered vector can still change if a higher-ranked request arrives first. Only the request that is offered in the cycle where both are high is acknowledged.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A one-cycle pulse on `irq_i[k]` makes source k pending from the next clock edge. It stays pending until it is acknowledged, whatever its level or enable.
- R2: `src_lvl_i[2k+1:2k]` sets the level of source k: 0 is low, 1 is medium, 2 or 3 is high. `lvl_en_i` bit 0 enables low, bit 1 enables medium and bit 2 enables high. A pending source whose level is disabled is not offered. It is offered as soon as its level is enabled again.
- R3: A request is offered only if its rank is above the highest active rank. The ranks run upward as low, medium, high, non-maskable. So medium preempts low, high preempts low and medium, and a level never preempts itself or a higher level.
- R4: A pending oscillator-failure request is offered ahead of every source, whatever the state of `lvl_en_i`, unless a non-maskable service is already active. It is reported with `irq_lvl_o` = 3.
- R5: Within the high level and the medium level, and within the low level when `rr_mode_i` = 0, the pending source with the lowest index is offered first.
- R6: When `rr_mode_i` = 1, acknowledging low source g makes the next low search start at index g+1, wrapping after the last source. The search point starts at 0 after reset and moves only on low acknowledges in this mode.
- R7: With base B = 0 when `boot_sel_i` = 0 and B = BOOT_BASE when it is 1, the vector is B+2 for the non-maskable request and B+4+SRC_STRIDE*k for source k. Address B+0 is left for reset.
- R8: An acknowledge happens when `irq_valid_o` and `irq_ready_i` are both high at a clock edge. From that edge on, bit L of `active_o` is set, where L is the level shown on `irq_lvl_o` (3 for the non-maskable request), and the acknowledged request is no longer pending.
- R9: A pulse on `reti_i` clears only the highest set bit of `active_o`. With no bit set, it has no effect.
- R10: After reset, nothing is pending, `active_o` is 0 and `irq_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Peripheral request pulses, one per source |
| nmi_i | input | 1 | Oscillator-failure request pulse |
| src_lvl_i | input | 2*N_SRC | Level per source, two bits each |
| lvl_en_i | input | 3 | Enables for the low, medium and high levels |
| rr_mode_i | input | 1 | 1 selects the rotating order within the low level |
| boot_sel_i | input | 1 | 1 places the vector table at BOOT_BASE |
| irq_valid_o | output | 1 | A vector is offered |
| irq_ready_i | input | 1 | Processor takes the offered vector |
| irq_vec_o | output | VEC_W | Offered word address |
| irq_lvl_o | output | 2 | Level of the offer: 0 low, 1 medium, 2 high, 3 non-maskable |
| reti_i | input | 1 | Return-from-interrupt pulse |
| active_o | output | 4 | Active flags: bit 0 low, bit 1 medium, bit 2 high, bit 3 non-maskable |

## Verification
If an active flag is wrong, the port effect comes one cycle later. A stale flag holds back a request that should preempt, so `irq_valid_o` stays low. A missing flag lets a request through that should wait. Both show up at the next offer after the faulty edge. If pending state is wrong, a source is either never offered or offered twice after its acknowledge. If the rotation pointer is wrong, the vector sequence differs from the wrapped search order on the very next low acknowledge. So sweeps over every source, every level pair and long rotating sequences expose these faults within a few cycles.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MED  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_NMI  = 2'd3
  } lvl_e;

  localparam int NMI_OFS = 2;
  localparam int SRC_OFS = 4;
endpackage

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         nmi_set_i,
  input  logic         nmi_clr_i,
  output logic [N-1:0] pend_o,
  output logic         nmi_pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= (bit_q & ~clr_i[k]) | set_i[k];
    end
    assign pend_o[k] = bit_q;

    // R1
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_q && !clr_i[k]) |=> pend_o[k]);
  end

  logic nmi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= (nmi_q & ~nmi_clr_i) | nmi_set_i;
  end
  assign nmi_pend_o = nmi_q;
endmodule

// File: rtl/irq_pick_fixed.sv
`timescale 1ns/1ps
module irq_pick_fixed #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_pick_rr.sv
`timescale 1ns/1ps
module irq_pick_rr #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;
  logic          hit_up;
  logic [IW-1:0] idx_up, idx_all;

  always_comb begin
    hit_up  = 1'b0;
    idx_up  = '0;
    idx_all = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_all = IW'(i);
      if (req_i[i] && (i >= int'(ptr_q))) begin
        hit_up = 1'b1;
        idx_up = IW'(i);
      end
    end
    any_o = |req_i;
    idx_o = hit_up ? idx_up : idx_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv_i) ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + 1'b1;
  end

  // R6
  rr_grant_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[idx_o]);

  // R6
  rr_ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (ptr_q != $past(idx_o)));
endmodule

// File: rtl/irq_nest_track.sv
`timescale 1ns/1ps
module irq_nest_track
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_i,
  input  lvl_e       acc_lvl_i,
  input  logic       reti_i,
  output logic [3:0] active_o,
  output logic [2:0] top_rank_o
);
  logic [3:0] act_q, act_d;

  always_comb begin
    top_rank_o = '0;
    for (int i = 0; i < 4; i++) begin
      if (act_q[i]) top_rank_o = 3'(i + 1);
    end
  end

  always_comb begin
    act_d = act_q;
    if (reti_i && (top_rank_o != 3'd0)) act_d[top_rank_o - 3'd1] = 1'b0;
    if (acc_i) act_d[acc_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end
  assign active_o = act_q;

  // R8
  ack_sets_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> active_o[$past(acc_lvl_i)]);

  // R9
  reti_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !acc_i && (act_q != 4'd0)) |=>
      ($countones(active_o) == $countones($past(active_o)) - 1));
endmodule

// File: rtl/irq_nest_ctrl.sv
`timescale 1ns/1ps
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int VEC_W      = 16,
  parameter int BOOT_BASE  = 'h1800,
  parameter int SRC_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   irq_i,
  input  logic               nmi_i,
  input  logic [2*N_SRC-1:0] src_lvl_i,
  input  logic [2:0]         lvl_en_i,
  input  logic               rr_mode_i,
  input  logic               boot_sel_i,
  output logic               irq_valid_o,
  input  logic               irq_ready_i,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [1:0]         irq_lvl_o,
  input  logic               reti_i,
  output logic [3:0]         active_o
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] pend, clr;
  logic             nmi_pend;
  logic [N_SRC-1:0] is_lo, is_md, is_hi;
  logic [N_SRC-1:0] req_lo, req_md, req_hi;
  logic             lo_any_f, lo_any_r, md_any, hi_any;
  logic [IW-1:0]    lo_idx_f, lo_idx_r, md_idx, hi_idx;
  logic             cand_any;
  lvl_e             cand_lvl;
  logic [IW-1:0]    cand_idx;
  logic [2:0]       cand_rank, top_rank;
  logic             accept, rr_adv;
  logic [VEC_W-1:0] base;

  for (genvar k = 0; k < N_SRC; k++) begin : g_cls
    assign is_lo[k] = (src_lvl_i[2*k +: 2] == 2'd0);
    assign is_md[k] = (src_lvl_i[2*k +: 2] == 2'd1);
    assign is_hi[k] = src_lvl_i[2*k + 1];
  end

  assign req_lo = pend & is_lo & {N_SRC{lvl_en_i[0]}};
  assign req_md = pend & is_md & {N_SRC{lvl_en_i[1]}};
  assign req_hi = pend & is_hi & {N_SRC{lvl_en_i[2]}};

  irq_pend_bank #(.N(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_i(irq_i), .clr_i(clr),
    .nmi_set_i(nmi_i), .nmi_clr_i(accept && (cand_lvl == LVL_NMI)),
    .pend_o(pend), .nmi_pend_o(nmi_pend)
  );

  irq_pick_fixed #(.N(N_SRC), .IW(IW)) u_pick_hi (
    .req_i(req_hi), .any_o(hi_any), .idx_o(hi_idx));
  irq_pick_fixed #(.N(N_SRC), .IW(IW)) u_pick_md (
    .req_i(req_md), .any_o(md_any), .idx_o(md_idx));
  irq_pick_fixed #(.N(N_SRC), .IW(IW)) u_pick_lo (
    .req_i(req_lo), .any_o(lo_any_f), .idx_o(lo_idx_f));
  irq_pick_rr #(.N(N_SRC), .IW(IW)) u_pick_rr (
    .clk(clk), .rst_n(rst_n), .req_i(req_lo), .adv_i(rr_adv),
    .any_o(lo_any_r), .idx_o(lo_idx_r));

  always_comb begin
    cand_any = 1'b1;
    cand_lvl = LVL_LOW;
    cand_idx = '0;
    if (nmi_pend) begin
      cand_lvl = LVL_NMI;
    end else if (hi_any) begin
      cand_lvl = LVL_HIGH;
      cand_idx = hi_idx;
    end else if (md_any) begin
      cand_lvl = LVL_MED;
      cand_idx = md_idx;
    end else if (rr_mode_i ? lo_any_r : lo_any_f) begin
      cand_idx = rr_mode_i ? lo_idx_r : lo_idx_f;
    end else begin
      cand_any = 1'b0;
    end
  end

  assign cand_rank   = {1'b0, cand_lvl} + 3'd1;
  assign irq_valid_o = cand_any && (cand_rank > top_rank);
  assign accept      = irq_valid_o && irq_ready_i;
  assign rr_adv      = accept && rr_mode_i && (cand_lvl == LVL_LOW);
  assign irq_lvl_o   = cand_lvl;

  always_comb begin
    clr = '0;
    if (accept && (cand_lvl != LVL_NMI)) clr[cand_idx] = 1'b1;
  end

  assign base = boot_sel_i ? VEC_W'(BOOT_BASE) : '0;
  always_comb begin
    if (cand_lvl == LVL_NMI)
      irq_vec_o = base + VEC_W'(NMI_OFS);
    else
      irq_vec_o = base + VEC_W'(SRC_OFS) + VEC_W'(SRC_STRIDE) * VEC_W'(cand_idx);
  end

  irq_nest_track u_nest (
    .clk(clk), .rst_n(rst_n),
    .acc_i(accept), .acc_lvl_i(cand_lvl), .reti_i(reti_i),
    .active_o(active_o), .top_rank_o(top_rank)
  );

  // R4
  nmi_always_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !active_o[3]) |-> (irq_valid_o && irq_lvl_o == 2'd3));

  // R3
  high_blocks_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && active_o[2]) |-> (irq_lvl_o == 2'd3));

  // R3
  med_blocks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && active_o[1]) |-> (irq_lvl_o >= 2'd2));

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_valid_o);
endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;
  localparam int N  = 8;
  localparam int BB = 'h1800;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic         nmi = 1'b0;
  logic [2*N-1:0] lvl = '0;
  logic [2:0]   en = 3'b111;
  logic         rr = 1'b0;
  logic         boot = 1'b0;
  logic         valid;
  logic         ready = 1'b0;
  logic [15:0]  vec;
  logic [1:0]   lvl_o;
  logic         reti = 1'b0;
  logic [3:0]   active;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_nest_ctrl #(.N_SRC(N), .VEC_W(16), .BOOT_BASE(BB), .SRC_STRIDE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi), .src_lvl_i(lvl),
    .lvl_en_i(en), .rr_mode_i(rr), .boot_sel_i(boot),
    .irq_valid_o(valid), .irq_ready_i(ready), .irq_vec_o(vec),
    .irq_lvl_o(lvl_o), .reti_i(reti), .active_o(active));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int src_vec(input int k, input logic b);
    return (b ? BB : 0) + 4 + 4 * k;
  endfunction

  task automatic pulse(input logic [N-1:0] m, input logic n);
    @(negedge clk); irq = m; nmi = n;
    @(negedge clk); irq = '0; nmi = 1'b0; #1;
  endtask

  task automatic take();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0; #1;
  endtask

  task automatic ret();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0; #1;
  endtask

  task automatic all_lvl(input int l);
    for (int k = 0; k < N; k++) lvl[2*k +: 2] = 2'(l);
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 valid", int'(valid), 0);
    chk("R10 active", int'(active), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 valid after release", int'(valid), 0);

    // R1 R7 R8 R9: every source, every level, both table bases
    for (int b = 0; b < 2; b++) begin
      for (int l = 0; l < 3; l++) begin
        for (int k = 0; k < N; k++) begin
          boot = b[0]; all_lvl(l);
          pulse(N'(1) << k, 1'b0);
          chk("R1 pending offered", int'(valid), 1);
          chk("R7 vector", int'(vec), src_vec(k, b[0]));
          chk("R2 level", int'(lvl_o), l);
          take();
          chk("R8 active set", int'(active), 1 << l);
          chk("R8 pend cleared", int'(valid), 0);
          ret();
          chk("R9 active cleared", int'(active), 0);
        end
      end
    end
    boot = 1'b0;

    // R2: enable gating keeps the request pending
    for (int l = 0; l < 3; l++) begin
      all_lvl(l);
      en = ~(3'(1) << l);
      pulse(8'h08, 1'b0);
      chk("R2 disabled not offered", int'(valid), 0);
      @(negedge clk); en = 3'b111; #1;
      chk("R2 re-enabled offered", int'(valid), 1);
      chk("R2 re-enabled vector", int'(vec), src_vec(3, 1'b0));
      take(); ret();
    end
    all_lvl(3);
    pulse(8'h04, 1'b0);
    chk("R2 code 3 is high", int'(lvl_o), 2);
    take(); ret();

    // R3: preemption matrix
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        lvl[1:0] = 2'(a); lvl[3:2] = 2'(b);
        pulse(8'h01, 1'b0); take();
        pulse(8'h02, 1'b0);
        chk("R3 preempt decision", int'(valid), (b > a) ? 1 : 0);
        if (b > a) begin
          chk("R3 preempt vector", int'(vec), src_vec(1, 1'b0));
          take();
          chk("R3 nested active", int'(active), (1 << a) | (1 << b));
          ret();
          chk("R9 inner closed", int'(active), 1 << a);
          ret();
        end else begin
          ret();
          chk("R3 offered after return", int'(valid), 1);
          chk("R3 waiting vector", int'(vec), src_vec(1, 1'b0));
          take(); ret();
        end
        chk("R9 all closed", int'(active), 0);
      end
    end

    // R4: non-maskable above everything, with enables off
    all_lvl(2);
    pulse(8'h01, 1'b0); take();
    en = 3'b000;
    pulse(8'h00, 1'b1);
    chk("R4 nmi offered", int'(valid), 1);
    chk("R4 nmi level", int'(lvl_o), 3);
    chk("R7 nmi vector", int'(vec), 2);
    take();
    chk("R8 nmi active", int'(active), 4'b1100);
    ret();
    chk("R9 nmi closed first", int'(active), 4'b0100);
    ret();
    chk("R9 reti on empty", int'(active), 0);
    ret();
    chk("R9 reti no effect", int'(active), 0);
    en = 3'b111; boot = 1'b1;
    pulse(8'h04, 1'b1);
    chk("R4 nmi beats high", int'(lvl_o), 3);
    chk("R7 nmi boot vector", int'(vec), BB + 2);
    take();
    chk("R4 nmi blocks high", int'(valid), 0);
    ret();
    chk("R3 high after nmi", int'(vec), src_vec(2, 1'b1));
    take(); ret();
    boot = 1'b0;

    // R5: fixed order within each level
    for (int l = 0; l < 3; l++) begin
      all_lvl(l);
      for (int mi = 0; mi < 4; mi++) begin
        logic [N-1:0] m;
        m = (mi == 0) ? 8'hA6 : (mi == 1) ? 8'h81 : (mi == 2) ? 8'h3C : 8'hFF;
        pulse(m, 1'b0);
        while (m != 0) begin
          int e;
          e = lowest(m);
          chk("R5 lowest first", int'(vec), src_vec(e, 1'b0));
          take(); ret();
          m[e] = 1'b0;
        end
        chk("R5 drained", int'(valid), 0);
      end
    end

    // R6: rotating order within low level, against a bench model
    begin
      int ptr;
      logic [N-1:0] pm;
      ptr = 0; pm = '0;
      all_lvl(0); rr = 1'b1;
      for (int s = 0; s < 40; s++) begin
        logic [N-1:0] nm;
        int e;
        nm = (N'(1) << ((s * 3) % N)) | (N'(1) << ((s * 5 + 1) % N));
        if (s < 30) pulse(nm, 1'b0);
        else nm = '0;
        pm = pm | nm;
        if (pm == 0) continue;
        e = -1;
        for (int i = 0; i < N; i++) if (e < 0 && pm[i] && i >= ptr) e = i;
        if (e < 0) e = lowest(pm);
        chk("R6 rotating grant", int'(vec), src_vec(e, 1'b0));
        take(); ret();
        pm[e] = 1'b0;
        ptr = (e + 1) % N;
      end
      rr = 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule